// File: doc/BRIEF.md
# Multi-channel indirect register access decoder

This block sits between a narrow microprocessor bus and a wide internal register space. The bus offers only a 7-bit address and an 8-bit data path, but the space behind it holds several thousand byte locations. The block splits the bus address into a channel number and a register group. Each group has a pointer register and a data window. Software first writes an offset into the pointer. It then reads or writes the data window, and the block forwards that access to the internal location that the channel, the group and the pointer together name.

Every channel keeps its own pointer for every group. Two of the groups are buffer ports and are not set up by software. Their offset comes from a counter that moves on by one after each data access, so a buffer can be streamed through a single address. Writing the buffer group's pointer address rewinds the counter to zero.

Reads are returned one clock after the read strobe and stay on the bus until the next read. Writes to a data window appear as a single-cycle internal write strobe in the same cycle as the bus write. The block holds no internal register contents of its own. The internal space answers through `int_rdata`.

Top module: `idx_reg_decoder`

## Requirements
- R1: The bus address is decoded as channel = `bus_addr[6:4]`, group = `bus_addr[3:1]`, and `bus_addr[0]` selects the pointer (0) or the data window (1).
- R2: The internal address is 13 bits wide and is formed as {channel (bits 12:10), group (bits 9:7), 7-bit offset (bits 6:0)}.
- R3: A write to the pointer address of a regular group (0 to 5) stores `bus_wdata[6:0]`. A read of that address returns {1'b0, stored pointer}.
- R4: A write to a data window drives `int_we` high for that cycle only. In the same cycle it drives `int_addr` from the current offset and drives `int_wdata` equal to `bus_wdata`. A write to a regular group's data window leaves its pointer unchanged.
- R5: A read of a data window drives `int_re` high in that cycle. From the next cycle, `bus_rdata` shows the `int_rdata` value that was present at that clock edge. `bus_rdata` keeps its value until the next read.
- R6: Pointers and counters are held separately per channel and per group. An access in one channel never changes another channel's offsets.
- R7: Groups 6 and 7 are buffer ports. Each read or write of their data window uses the counter as the offset and then adds one to the counter, wrapping from 127 to 0.
- R8: A write to a buffer group's pointer address clears its counter to zero, whatever the data. A read of that address returns {1'b0, counter}.
- R9: When `bus_wr` and `bus_rd` are high together, the access is a write only: `int_re` stays low and `bus_rdata` is not updated.
- R10: Accesses to pointer addresses never raise `int_we` or `int_re`.
- R11: After reset, every pointer and counter is zero, `bus_rdata` is zero, and no internal strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 7 | Bus address: channel, group, pointer/data select |
| bus_wdata | input | 8 | Bus write data |
| bus_wr | input | 1 | Bus write strobe, one access per high cycle |
| bus_rd | input | 1 | Bus read strobe, one access per high cycle |
| bus_rdata | output | 8 | Registered read data |
| int_addr | output | 13 | Internal location address |
| int_wdata | output | 8 | Internal write data |
| int_we | output | 1 | Internal write strobe |
| int_re | output | 1 | Internal read strobe |
| int_rdata | input | 8 | Data returned by the internal space for `int_addr` |

## Verification
The internal strobes, `int_addr` and `int_wdata` are combinational and due in the same cycle as the bus strobe. The bench therefore samples them one time unit after it drives the inputs, well before the clock edge. Pointer and counter updates, and the read data, take effect at that edge. They are due on `bus_rdata` or on the following access's `int_addr` from the next cycle on, and the bench compares them just after the next falling edge, before it applies new stimulus. A behavioural model of pointers, counters and a shadow memory predicts each value for the cycle in which it is due. The model is updated only after the current cycle's outputs have been compared.

// File: rtl/idx_pkg.sv
package idx_pkg;
  localparam int CHAN_W  = 3;
  localparam int GRP_W   = 3;
  localparam int PTR_W   = 7;
  localparam int DATA_W  = 8;
  localparam int BUF_A   = 6;
  localparam int BUF_B   = 7;
  localparam int NCH     = 1 << CHAN_W;
  localparam int NGRP    = 1 << GRP_W;
  localparam int EXT_AW  = CHAN_W + GRP_W + 1;
  localparam int INT_AW  = CHAN_W + GRP_W + PTR_W;
  localparam int NSLOT   = NCH * NGRP;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic [GRP_W-1:0]  grp;
    logic              odd;
    logic              is_buf;
    logic              rd_eff;
    logic              ptr_ld;
    logic              ptr_clr;
    logic              ptr_adv;
    logic              we;
    logic              re;
  } dec_t;
endpackage

// File: rtl/idx_addr_dec.sv
module idx_addr_dec
  import idx_pkg::*;
(
  input  logic [EXT_AW-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output dec_t              dec
);
  logic [CHAN_W-1:0] chan_f;
  logic [GRP_W-1:0]  grp_f;
  logic              odd_f;
  logic              buf_f;
  logic              rd_only;

  always_comb begin
    chan_f  = addr[EXT_AW-1 -: CHAN_W];
    grp_f   = addr[GRP_W:1];
    odd_f   = addr[0];
    buf_f   = (grp_f == GRP_W'(BUF_A)) || (grp_f == GRP_W'(BUF_B));
    rd_only = rd & ~wr;
  end

  always_comb begin
    dec.chan    = chan_f;
    dec.grp     = grp_f;
    dec.odd     = odd_f;
    dec.is_buf  = buf_f;
    dec.rd_eff  = rd_only;
    dec.ptr_ld  = wr & ~odd_f & ~buf_f;
    dec.ptr_clr = wr & ~odd_f & buf_f;
    dec.ptr_adv = odd_f & buf_f & (wr | rd_only);
    dec.we      = wr & odd_f;
    dec.re      = rd_only & odd_f;
  end
endmodule

// File: rtl/idx_ptr_bank.sv
module idx_ptr_bank
  import idx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  dec_t              dec,
  input  logic [DATA_W-1:0] wdata,
  output logic [PTR_W-1:0]  sel_ptr
);
  localparam int SLOT_W = CHAN_W + GRP_W;

  logic [PTR_W-1:0] ptr_all [NSLOT];

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      logic             hit;
      logic             en;
      logic [PTR_W-1:0] ptr_q;
      logic [PTR_W-1:0] ptr_d;

      always_comb begin
        hit   = (dec.chan == CHAN_W'(c)) && (dec.grp == GRP_W'(g));
        en    = hit & (dec.ptr_ld | dec.ptr_clr | dec.ptr_adv);
        ptr_d = ptr_q;
        if (dec.ptr_ld)       ptr_d = wdata[PTR_W-1:0];
        else if (dec.ptr_clr) ptr_d = '0;
        else if (dec.ptr_adv) ptr_d = ptr_q + PTR_W'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  ptr_q <= '0;
        else if (en) ptr_q <= ptr_d;
      end

      assign ptr_all[c*NGRP + g] = ptr_q;
    end
  end

  logic [SLOT_W-1:0] slot;
  always_comb begin
    slot    = {dec.chan, dec.grp};
    sel_ptr = ptr_all[slot];
  end
endmodule

// File: rtl/idx_rd_ret.sv
module idx_rd_ret
  import idx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  dec_t              dec,
  input  logic [PTR_W-1:0]  sel_ptr,
  input  logic [DATA_W-1:0] int_rdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rdata_d;
  logic              rdata_en;

  always_comb begin
    rdata_en = dec.rd_eff;
    if (dec.odd) rdata_d = int_rdata;
    else         rdata_d = DATA_W'(sel_ptr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata <= '0;
    else if (rdata_en) rdata <= rdata_d;
  end
endmodule

// File: rtl/idx_reg_decoder.sv
module idx_reg_decoder
  import idx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EXT_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [INT_AW-1:0] int_addr,
  output logic [DATA_W-1:0] int_wdata,
  output logic              int_we,
  output logic              int_re,
  input  logic [DATA_W-1:0] int_rdata
);
  // reset: asserted at once, released after two edges
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  dec_t             dec;
  logic [PTR_W-1:0] sel_ptr;

  idx_addr_dec u_dec (
    .addr (bus_addr),
    .wr   (bus_wr),
    .rd   (bus_rd),
    .dec  (dec)
  );

  idx_ptr_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .dec     (dec),
    .wdata   (bus_wdata),
    .sel_ptr (sel_ptr)
  );

  idx_rd_ret u_ret (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .dec       (dec),
    .sel_ptr   (sel_ptr),
    .int_rdata (int_rdata),
    .rdata     (bus_rdata)
  );

  always_comb begin
    int_addr  = {dec.chan, dec.grp, sel_ptr};
    int_wdata = bus_wdata;
    int_we    = dec.we & rst_sync_n;
    int_re    = dec.re & rst_sync_n;
  end
endmodule

// File: rtl/idx_reg_decoder_chk.sv
module idx_reg_decoder_chk
  import idx_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [EXT_AW-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [INT_AW-1:0] int_addr,
  input logic              int_we,
  input logic              int_re,
  input logic [DATA_W-1:0] int_rdata
);
  logic              buf_acc;
  logic              prev_buf_q;
  logic [EXT_AW-1:0] prev_addr_q;
  logic [PTR_W-1:0]  prev_off_q;

  always_comb begin
    buf_acc = bus_addr[0] && (bus_wr || bus_rd) &&
              ((bus_addr[GRP_W:1] == GRP_W'(BUF_A)) ||
               (bus_addr[GRP_W:1] == GRP_W'(BUF_B)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_buf_q  <= 1'b0;
      prev_addr_q <= '0;
      prev_off_q  <= '0;
    end else begin
      prev_buf_q  <= buf_acc;
      prev_addr_q <= bus_addr;
      prev_off_q  <= int_addr[PTR_W-1:0];
    end
  end

  // R4 and R2: a data write strobes in the same cycle toward the decoded channel and group
  a_r4_write_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[0]) |->
      (int_we && int_addr[INT_AW-1 -: CHAN_W+GRP_W] == bus_addr[EXT_AW-1:1]));

  a_r10_pointer_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr[0] |-> (!int_we && !int_re));

  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_rd) |-> !int_re);

  a_r5_read_return: assert property (@(posedge clk) disable iff (!rst_n)
    int_re |=> (bus_rdata == $past(int_rdata)));

  a_r5_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && !bus_wr) |=> $stable(bus_rdata));

  a_r7_buffer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_acc && prev_buf_q && bus_addr == prev_addr_q) |->
      (int_addr[PTR_W-1:0] == PTR_W'(prev_off_q + PTR_W'(1))));

  always_comb begin
    if (rst_n) a_r4_strobes_exclusive: assert (!(int_we && int_re));
  end
endmodule

bind idx_reg_decoder idx_reg_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .int_addr  (int_addr),
  .int_we    (int_we),
  .int_re    (int_re),
  .int_rdata (int_rdata)
);

// File: tb/sim_idx_reg_decoder.sv
module sim_idx_reg_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_wr;
  logic       bus_rd;
  logic [7:0] bus_rdata;
  logic [12:0] int_addr;
  logic [7:0] int_wdata;
  logic       int_we;
  logic       int_re;
  logic [7:0] int_rdata;

  logic [7:0] mem [0:8191];

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int m_ptr [8][8];
  int m_rdata;
  logic [7:0] smem [0:8191];

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_reg_decoder u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .int_addr  (int_addr),
    .int_wdata (int_wdata),
    .int_we    (int_we),
    .int_re    (int_re),
    .int_rdata (int_rdata)
  );

  function automatic logic [7:0] pat(int i);
    return 8'((i * 7) ^ (i >> 5));
  endfunction

  assign int_rdata = mem[int_addr];
  always @(posedge clk) if (int_we) mem[int_addr] <= int_wdata;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one bus cycle: compare registered result, drive, compare same-cycle outputs, update model
  task automatic cyc(bit wr, bit rd, logic [6:0] a, logic [7:0] d);
    int ch, g, p, ia;
    bit odd, isb, eff;
    string tag;
    @(negedge clk);
    chk(bus_rdata === 8'(m_rdata), "R5 bus_rdata", bus_rdata, m_rdata);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    #1;
    ch = int'(a[6:4]); g = int'(a[3:1]); odd = a[0];
    isb = (g >= 6); eff = rd && !wr; p = m_ptr[ch][g];
    ia = ch * 1024 + g * 128 + p;
    tag = !odd ? "R10" : (wr && rd) ? "R9" : "R4";
    chk(int_we === (wr && odd), {tag, " int_we"}, int_we, int'(wr && odd));
    tag = !odd ? "R10" : (wr && rd) ? "R9" : "R5";
    chk(int_re === (eff && odd), {tag, " int_re"}, int_re, int'(eff && odd));
    if (odd && (wr || rd))
      chk(int_addr === 13'(ia), isb ? "R7 int_addr" : "R2 int_addr", int_addr, ia);
    if (wr && odd) chk(int_wdata === d, "R4 int_wdata", int_wdata, d);
    if (eff) m_rdata = odd ? int'(smem[ia]) : p;
    if (wr && odd) smem[ia] = d;
    if (wr && !odd) m_ptr[ch][g] = isb ? 0 : int'(d[6:0]);
    if (odd && (wr || rd) && isb) m_ptr[ch][g] = (p + 1) % 128;
  endtask

  task automatic rd_expect(logic [6:0] a, int exp, string req);
    cyc(0, 1, a, 8'h00);
    @(posedge clk); #1;
    chk(bus_rdata === 8'(exp), req, bus_rdata, exp);
  endtask

  function automatic logic [6:0] adr(int ch, int g, bit odd);
    return 7'(ch * 16 + g * 2 + int'(odd));
  endfunction

  initial begin
    for (int i = 0; i < 8192; i++) begin
      mem[i] = pat(i);
      smem[i] = pat(i);
    end
    for (int c = 0; c < 8; c++) for (int g = 0; g < 8; g++) m_ptr[c][g] = 0;
    m_rdata = 0;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(bus_rdata === 8'h00, "R11 reset rdata", bus_rdata, 0);
    chk(int_we === 1'b0 && int_re === 1'b0, "R11 reset strobes", {int_we, int_re}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R11: pointers read zero after reset
    rd_expect(adr(4, 3, 0), 0, "R11 pointer after reset");
    rd_expect(adr(7, 6, 0), 0, "R11 counter after reset");

    // R3 / R1: pointer write and readback, bit 7 dropped
    cyc(1, 0, adr(0, 0, 0), 8'h05);
    cyc(1, 0, adr(1, 0, 0), 8'h09);
    cyc(1, 0, adr(0, 2, 0), 8'h7F);
    cyc(1, 0, adr(3, 1, 0), 8'hFF);
    rd_expect(adr(0, 0, 0), 8'h05, "R3 pointer readback");
    rd_expect(adr(3, 1, 0), 8'h7F, "R3 pointer bit7 dropped");
    rd_expect(adr(0, 2, 0), 8'h7F, "R1 group field decode");

    // R4 / R5: data write then read through window
    cyc(1, 0, adr(0, 0, 1), 8'h3C);
    rd_expect(adr(0, 0, 1), 8'h3C, "R5 data readback");
    rd_expect(adr(0, 0, 0), 8'h05, "R4 pointer unchanged by data write");

    // R6: other channel same group
    rd_expect(adr(1, 0, 1), int'(pat(1 * 1024 + 9)), "R6 channel 1 data");
    rd_expect(adr(1, 0, 0), 8'h09, "R6 channel 1 pointer");
    rd_expect(adr(0, 0, 0), 8'h05, "R6 channel 0 pointer kept");

    // R7 / R8: buffer streaming
    cyc(1, 0, adr(2, 6, 0), 8'hAA);
    cyc(1, 0, adr(2, 6, 1), 8'h11);
    cyc(1, 0, adr(2, 6, 1), 8'h22);
    cyc(1, 0, adr(2, 6, 1), 8'h33);
    rd_expect(adr(2, 6, 0), 3, "R8 counter readback");
    rd_expect(adr(2, 7, 0), 0, "R6 sibling buffer counter");
    cyc(1, 0, adr(2, 6, 0), 8'h55);
    rd_expect(adr(2, 6, 0), 0, "R8 counter cleared");
    rd_expect(adr(2, 6, 1), 8'h11, "R7 buffer byte 0");
    rd_expect(adr(2, 6, 1), 8'h22, "R7 buffer byte 1");
    rd_expect(adr(2, 6, 1), 8'h33, "R7 buffer byte 2");

    // R7: counter wrap
    cyc(1, 0, adr(5, 7, 0), 8'h00);
    for (int i = 0; i < 130; i++) cyc(0, 1, adr(5, 7, 1), 8'h00);
    rd_expect(adr(5, 7, 0), 2, "R7 counter wrap");

    // R9: write and read together
    rd_expect(adr(0, 0, 1), 8'h3C, "R9 setup");
    cyc(1, 1, adr(0, 0, 1), 8'h77);
    @(posedge clk); #1;
    chk(bus_rdata === 8'h3C, "R9 rdata not updated", bus_rdata, 8'h3C);
    cyc(1, 1, adr(6, 4, 0), 8'h12);
    rd_expect(adr(6, 4, 0), 8'h12, "R9 pointer write with rd high");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      cyc(r < 3, (r >= 3 && r < 7) || r == 9, 7'($urandom), 8'($urandom));
    end
    for (int i = 0; i < 3; i++) cyc(0, 0, 7'h00, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule